// File: doc/BRIEF.md
# Wishbone Single-Cycle Master Bridge

This block accepts one load or store request at a time from a processor and carries it out as a single Wishbone B.3 read or write cycle. A request gives a 40-bit physical address, an access size of 1, 2, 4 or 8 bytes, a direction flag and right-justified store data. The bridge forms a 64-bit bus address. The top five bits of that address hold a one-hot target region, which is decoded from the physical address. The bridge places the data and byte selects in big-endian lane order. It then holds the cycle open until the slave acknowledges it.

The request side uses a valid/ready handshake with back-pressure. The requester raises `req_valid` and keeps every request field steady until it sees `req_ready`. `req_ready` is a single-clock pulse that ends the transaction. While the pulse is high, `rsp_rdata` and `rsp_misalign` are valid. The requester must lower `req_valid`, or present the next request, before the following clock edge.

A request that is not naturally aligned never reaches the bus. The bridge answers it directly with the misalign flag set. Load data is registered when the acknowledge arrives. The addressed bytes are shifted down to bit 0 and zero-extended.

Top module: `wb_single_bridge`

## Requirements
- R1: During a bus cycle, address bits [58:40] and [2:0] are zero, and bits [39:3] equal request address bits [39:3].
- R2: When request address bit 39 is 0 (top byte 0x00-0x7F, RAM), exactly address bit 59+k is set among bits [63:59], where k is the value of request address bits [38:37].
- R3: When request address bit 39 is 1 (register space), address bit 63 alone is set among bits [63:59]. For example, address 0x9F_0000_0000 is issued as 0x8000_009F_0000_0000.
- R4: Exactly one of address bits [63:59] is high in every cycle in which `wbm_cyc_o` is high.
- R5: Size code 0/1/2/3 means 1/2/4/8 bytes. Byte offset o (request address bits [2:0]) maps to `wbm_sel_o` bit 7-o. An n-byte access at offset o selects bits 7-o down to 8-o-n.
- R6: On a store, `wbm_we_o` is 1 and `wbm_dat_o` carries the low n bytes of `req_wdata` in the selected lanes, with the byte at offset o in bits [63-8o:56-8o]. Unselected lanes are zero. On a load, `wbm_we_o` is 0.
- R7: `wbm_cyc_o` and `wbm_stb_o` rise together one clock after a valid aligned request is seen while idle. They stay high, with address, select, data and direction unchanged, until the clock in which `wbm_ack_i` is sampled high.
- R8: `req_ready` is high for exactly one clock, in the clock after the acknowledge. `wbm_cyc_o` is low in that clock.
- R9: On a load, `rsp_rdata` holds the selected bytes of `wbm_dat_i`, captured at the acknowledge, right-justified and zero-extended to 64 bits.
- R10: A request is misaligned when the offset is not a multiple of the size: a 2-byte access at an odd offset, a 4-byte access at an offset other than 0 or 4, or an 8-byte access at a nonzero offset. Such a request raises no bus cycle. It gets a `req_ready` pulse one clock later with `rsp_misalign` at 1. Aligned requests return `rsp_misalign` at 0.
- R11: While `rst_n` is low, and right after it is released, `wbm_cyc_o`, `wbm_stb_o` and `req_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_ready | output | 1 | One-clock completion pulse; response fields valid |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 40 | Physical byte address |
| req_size | input | 2 | 0/1/2/3 = 1/2/4/8 bytes |
| req_wdata | input | 64 | Store data, right-justified |
| rsp_rdata | output | 64 | Load data, right-justified, zero-extended |
| rsp_misalign | output | 1 | Request was misaligned and not issued |
| wbm_adr_o | output | 64 | Bus address with region bits |
| wbm_dat_o | output | 64 | Bus write data, big-endian lanes |
| wbm_sel_o | output | 8 | Byte selects, bit 7 = offset 0 |
| wbm_we_o | output | 1 | Bus write enable |
| wbm_cyc_o | output | 1 | Bus cycle |
| wbm_stb_o | output | 1 | Bus strobe |
| wbm_ack_i | input | 1 | Slave acknowledge |
| wbm_dat_i | input | 64 | Bus read data |

## Verification
A fault in the region decoder shows up on the first issued cycle, one clock after the request. It appears as a wrong or non-one-hot top byte of `wbm_adr_o`. A fault in the lane logic shows up in the same clock, as shifted or mirrored select bits or as stray write bytes. Register-space addresses and all four RAM banks are each visited to expose it. A stuck or mis-sequenced control state shows up within a clock of the acknowledge: a missing, doubled or early `req_ready`, or `wbm_cyc_o` still high beside it. A bad extraction shows in `rsp_rdata` during the same pulse. The stimulus places distinct byte values in every lane, so a wrong lane is never hidden by a repeated value.

// File: rtl/wbb_pkg.sv
package wbb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_DONE = 2'd2
  } wbb_state_e;

  // number of bytes for a size code
  function automatic int wbb_nbytes(input logic [1:0] size);
    return 1 << size;
  endfunction

  // byte distance from the lowest selected lane to lane 0 (bits [7:0])
  function automatic int wbb_lane_shift(input int bytes, input int off, input logic [1:0] size);
    return bytes - off - wbb_nbytes(size);
  endfunction

endpackage

// File: rtl/wbb_region_dec.sv
module wbb_region_dec #(
  parameter int PA_W  = 40,
  parameter int REG_W = 5
) (
  input  logic [PA_W-1:0]  pa,
  output logic [REG_W-1:0] region
);
  localparam int IO_BIT = REG_W - 1;

  always_comb begin
    region = '0;
    if (pa[PA_W-1]) begin
      region[IO_BIT] = 1'b1;
    end else begin
      region[pa[PA_W-2 -: 2]] = 1'b1;
    end
  end

  // R4
  region_dec_onehot_chk: assert final ($onehot(region) || $isunknown(pa));

endmodule

// File: rtl/wbb_lane_map.sv
module wbb_lane_map
  import wbb_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic [1:0]        size,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  output logic [BYTES-1:0]  sel,
  output logic [DATA_W-1:0] dat,
  output logic              misalign
);
  int lo, hi, sh;
  logic [DATA_W-1:0] shifted;
  logic [OFF_W:0]    nb_m1;

  always_comb begin
    lo      = int'(off);
    hi      = lo + wbb_nbytes(size);
    sh      = wbb_lane_shift(BYTES, lo, size);
    nb_m1   = (OFF_W+1)'(wbb_nbytes(size) - 1);
    misalign = (({1'b0, off} & nb_m1) != '0);
    shifted = (sh >= 0) ? (wdata << (8 * sh)) : '0;
  end

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    assign sel[BYTES-1-i] = (i >= lo) && (i < hi);
    assign dat[8*(BYTES-1-i) +: 8] = sel[BYTES-1-i] ? shifted[8*(BYTES-1-i) +: 8] : 8'h00;
  end

endmodule

// File: rtl/wbb_rd_extract.sv
module wbb_rd_extract
  import wbb_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic [1:0]        size,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] bus_dat,
  output logic [DATA_W-1:0] rdata
);
  int sh, nb;
  logic [DATA_W-1:0] down;

  always_comb begin
    sh   = wbb_lane_shift(BYTES, int'(off), size);
    nb   = wbb_nbytes(size);
    down = (sh >= 0) ? (bus_dat >> (8 * sh)) : '0;
  end

  for (genvar k = 0; k < BYTES; k++) begin : g_byte
    assign rdata[8*k +: 8] = (k < nb) ? down[8*k +: 8] : 8'h00;
  end

endmodule

// File: rtl/wb_single_bridge.sv
module wb_single_bridge
  import wbb_pkg::*;
#(
  parameter int PA_W   = 40,
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_we,
  input  logic [PA_W-1:0]     req_addr,
  input  logic [1:0]          req_size,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                rsp_misalign,
  output logic [ADDR_W-1:0]   wbm_adr_o,
  output logic [DATA_W-1:0]   wbm_dat_o,
  output logic [DATA_W/8-1:0] wbm_sel_o,
  output logic                wbm_we_o,
  output logic                wbm_cyc_o,
  output logic                wbm_stb_o,
  input  logic                wbm_ack_i,
  input  logic [DATA_W-1:0]   wbm_dat_i
);
  localparam int BYTES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(BYTES);
  localparam int REG_W  = 5;
  localparam int ZERO_W = ADDR_W - REG_W - PA_W;

  wbb_state_e state_q;

  logic [REG_W-1:0]  region_c;
  logic [BYTES-1:0]  sel_c;
  logic [DATA_W-1:0] dat_c;
  logic              mis_c;
  logic [DATA_W-1:0] rd_c;

  logic [1:0]        size_q;
  logic [OFF_W-1:0]  off_q;

  wbb_region_dec #(.PA_W(PA_W), .REG_W(REG_W)) u_region (
    .pa     (req_addr),
    .region (region_c)
  );

  wbb_lane_map #(.DATA_W(DATA_W)) u_lanes (
    .size     (req_size),
    .off      (req_addr[OFF_W-1:0]),
    .wdata    (req_wdata),
    .sel      (sel_c),
    .dat      (dat_c),
    .misalign (mis_c)
  );

  wbb_rd_extract #(.DATA_W(DATA_W)) u_rd (
    .size    (size_q),
    .off     (off_q),
    .bus_dat (wbm_dat_i),
    .rdata   (rd_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      wbm_adr_o    <= '0;
      wbm_dat_o    <= '0;
      wbm_sel_o    <= '0;
      wbm_we_o     <= 1'b0;
      size_q       <= '0;
      off_q        <= '0;
      rsp_rdata    <= '0;
      rsp_misalign <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            size_q       <= req_size;
            off_q        <= req_addr[OFF_W-1:0];
            rsp_misalign <= mis_c;
            if (mis_c) begin
              state_q <= ST_DONE;
            end else begin
              wbm_adr_o <= {region_c, {ZERO_W{1'b0}}, req_addr[PA_W-1:OFF_W], {OFF_W{1'b0}}};
              wbm_dat_o <= req_we ? dat_c : '0;
              wbm_sel_o <= sel_c;
              wbm_we_o  <= req_we;
              state_q   <= ST_BUS;
            end
          end
        end
        ST_BUS: begin
          if (wbm_ack_i) begin
            if (!wbm_we_o) rsp_rdata <= rd_c;
            state_q <= ST_DONE;
          end
        end
        default: begin
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign wbm_cyc_o = (state_q == ST_BUS);
  assign wbm_stb_o = (state_q == ST_BUS);
  assign req_ready = (state_q == ST_DONE);

  // R4
  region_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wbm_cyc_o |-> $onehot(wbm_adr_o[ADDR_W-1 -: REG_W]));

  // R1
  adr_zero_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wbm_cyc_o |-> (wbm_adr_o[OFF_W-1:0] == '0 && wbm_adr_o[PA_W +: ZERO_W] == '0));

  // R5
  sel_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wbm_cyc_o |-> (wbm_sel_o != '0));

  // R7
  cycle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wbm_cyc_o && !wbm_ack_i) |=> (wbm_cyc_o && wbm_stb_o && $stable(wbm_adr_o)
                                   && $stable(wbm_sel_o) && $stable(wbm_dat_o) && $stable(wbm_we_o)));

  // R8
  ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  // R8
  ready_no_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !wbm_cyc_o);

  // R8
  ack_then_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wbm_cyc_o && wbm_ack_i) |=> req_ready);

  // R10
  misalign_unissued_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && rsp_misalign) |-> !$past(wbm_cyc_o));

endmodule

// File: tb/wb_single_bridge_tb.sv
`timescale 1ns/1ps
module wb_single_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [39:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic [63:0] rsp_rdata;
  logic        rsp_misalign;
  logic [63:0] wbm_adr_o;
  logic [63:0] wbm_dat_o;
  logic [7:0]  wbm_sel_o;
  logic        wbm_we_o;
  logic        wbm_cyc_o;
  logic        wbm_stb_o;
  logic        wbm_ack_i = 1'b0;
  logic [63:0] wbm_dat_i = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  wb_single_bridge u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_misalign(rsp_misalign),
    .wbm_adr_o(wbm_adr_o), .wbm_dat_o(wbm_dat_o), .wbm_sel_o(wbm_sel_o),
    .wbm_we_o(wbm_we_o), .wbm_cyc_o(wbm_cyc_o), .wbm_stb_o(wbm_stb_o),
    .wbm_ack_i(wbm_ack_i), .wbm_dat_i(wbm_dat_i)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // one complete aligned transaction with a slave that waits `waits` clocks
  task automatic run_txn(input logic we, input logic [39:0] pa, input logic [1:0] sz,
                         input logic [63:0] wd, input logic [63:0] bus_rd, input int waits,
                         input logic [63:0] exp_adr, input logic [7:0] exp_sel,
                         input logic [63:0] exp_wdat, input logic [63:0] exp_rd);
    req_valid = 1'b1; req_we = we; req_addr = pa; req_size = sz; req_wdata = wd;
    @(negedge clk);
    chk(wbm_cyc_o && wbm_stb_o, "R7 cyc/stb raised", {62'b0, wbm_cyc_o, wbm_stb_o}, 64'h3);
    chk(wbm_adr_o[58:0] == exp_adr[58:0], "R1 address body", wbm_adr_o, exp_adr);
    chk(wbm_adr_o[63:59] == exp_adr[63:59], exp_adr[63] ? "R3 register region" : "R2 RAM bank region",
        wbm_adr_o, exp_adr);
    chk(wbm_sel_o == exp_sel, "R5 byte selects", {56'b0, wbm_sel_o}, {56'b0, exp_sel});
    chk(wbm_we_o == we, "R6 direction", {63'b0, wbm_we_o}, {63'b0, we});
    if (we) chk(wbm_dat_o == exp_wdat, "R6 write lanes", wbm_dat_o, exp_wdat);
    for (int w = 0; w < waits; w++) begin
      @(negedge clk);
      chk(wbm_cyc_o && wbm_stb_o && wbm_adr_o == exp_adr && wbm_sel_o == exp_sel && !req_ready,
          "R7 hold until ack", wbm_adr_o, exp_adr);
    end
    wbm_ack_i = 1'b1; wbm_dat_i = bus_rd;
    @(negedge clk);
    wbm_ack_i = 1'b0; wbm_dat_i = 64'hDEAD_DEAD_DEAD_DEAD;
    chk(req_ready == 1'b1, "R8 ready after ack", {63'b0, req_ready}, 64'h1);
    chk(wbm_cyc_o == 1'b0, "R8 no cycle with ready", {63'b0, wbm_cyc_o}, 64'h0);
    chk(rsp_misalign == 1'b0, "R10 aligned not flagged", {63'b0, rsp_misalign}, 64'h0);
    if (!we) chk(rsp_rdata == exp_rd, "R9 read data", rsp_rdata, exp_rd);
    req_valid = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b0 && wbm_cyc_o == 1'b0, "R8 single pulse", {62'b0, req_ready, wbm_cyc_o}, 64'h0);
  endtask

  task automatic run_misalign(input logic [39:0] pa, input logic [1:0] sz);
    req_valid = 1'b1; req_we = 1'b1; req_addr = pa; req_size = sz; req_wdata = 64'h0123_4567_89AB_CDEF;
    @(negedge clk);
    chk(wbm_cyc_o == 1'b0 && wbm_stb_o == 1'b0, "R10 misaligned not issued", {62'b0, wbm_cyc_o, wbm_stb_o}, 64'h0);
    chk(req_ready && rsp_misalign, "R10 misaligned flagged", {62'b0, req_ready, rsp_misalign}, 64'h3);
    req_valid = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b0 && wbm_cyc_o == 1'b0, "R10 no later cycle", {62'b0, req_ready, wbm_cyc_o}, 64'h0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!wbm_cyc_o && !wbm_stb_o && !req_ready, "R11 in reset", {61'b0, wbm_cyc_o, wbm_stb_o, req_ready}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!wbm_cyc_o && !wbm_stb_o && !req_ready, "R11 after reset", {61'b0, wbm_cyc_o, wbm_stb_o, req_ready}, 64'h0);
  endtask

  // byte store in bank 0, offset 3
  task automatic t_store_byte();
    run_txn(1'b1, 40'h12_3456_7803, 2'd0, 64'hFFFF_FFFF_FFFF_FFAB, '0, 0,
            64'h0800_0012_3456_7800, 8'h10, 64'h0000_00AB_0000_0000, '0);
  endtask

  // word store in bank 2, offset 4, slow slave
  task automatic t_store_word_wait();
    run_txn(1'b1, 40'h40_0000_1004, 2'd2, 64'h5555_5555_DEAD_BEEF, '0, 3,
            64'h2000_0040_0000_1000, 8'h0F, 64'h0000_0000_DEAD_BEEF, '0);
  endtask

  // double store in bank 3
  task automatic t_store_double();
    run_txn(1'b1, 40'h7F_FFFF_FFF8, 2'd3, 64'h0102_0304_0506_0708, '0, 1,
            64'h4000_007F_FFFF_FFF8, 8'hFF, 64'h0102_0304_0506_0708, '0);
  endtask

  // byte load in bank 1, last lane
  task automatic t_load_byte();
    run_txn(1'b0, 40'h20_0000_0007, 2'd0, '0, 64'h1122_3344_5566_7788, 0,
            64'h1000_0020_0000_0000, 8'h01, '0, 64'h88);
  endtask

  // half load from interrupt controller space
  task automatic t_load_half_io();
    run_txn(1'b0, 40'h9F_0000_0002, 2'd1, '0, 64'h1122_3344_5566_7788, 2,
            64'h8000_009F_0000_0000, 8'h30, '0, 64'h3344);
  endtask

  // word load from boot ROM space, offset 0
  task automatic t_load_word_rom();
    run_txn(1'b0, 40'hFF_0000_0000, 2'd2, '0, 64'hA1B2_C3D4_E5F6_0718, 0,
            64'h8000_00FF_0000_0000, 8'hF0, '0, 64'hA1B2_C3D4);
  endtask

  // double load from clock space
  task automatic t_load_double_io();
    run_txn(1'b0, 40'h96_0000_0008, 2'd3, '0, 64'hF0E1_D2C3_B4A5_9687, 1,
            64'h8000_0096_0000_0008, 8'hFF, '0, 64'hF0E1_D2C3_B4A5_9687);
  endtask

  task automatic t_misaligned();
    run_misalign(40'h00_0000_0001, 2'd1);
    run_misalign(40'h00_0000_0002, 2'd2);
    run_misalign(40'h00_0000_0004, 2'd3);
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    t_reset();
    t_store_byte();
    t_store_word_wait();
    t_store_double();
    t_load_byte();
    t_load_half_io();
    t_load_word_rom();
    t_load_double_io();
    t_misaligned();
    t_load_byte();
    finished = 1;
    summary();
    $finish;
  end

endmodule